// File: doc/BRIEF.md
# Two-Processor Mailbox Flag Controller

The block lets two processors signal each other through per-channel "occupied" flags. Each processor has a small register window on a shared word-wide bus, picked by a processor-select input. A processor raises its own flag on a channel to post a message. The partner sees the flag and, once it has taken the message, clears the sender's flag through its own command register. The handshake therefore crosses between the two register banks.

Each processor can read its own occupied flags. It finds messages pending for it by reading its partner's status window. A configuration register reports how many channels are implemented. Two level interrupt outputs per processor report a message waiting for it and at least one of its own channels being free.

Top module: `mbx_flag_ctrl`

## Requirements
- R1: After reset, every occupied flag in both banks is 0.
- R2: The window base is the processor number times 0x10. The command register is at base+0x08 and the status register at base+0x0C. The configuration register is at 0x3F0 and reads the same from either processor. It is reached by the address alone, so the select has no effect on its decode.
- R3: Writing 1 to bit 16+n of processor p's command register sets p's flag for channel n. The flag is visible in p's status register (bits NCH-1:0) on the cycle after the write.
- R4: Writing 1 to bit n of processor p's command register clears the other processor's flag for channel n. Processor p's own flags are not changed.
- R5: Zeros written to the command register have no effect. Command bits for channels at or above NCH have no effect. Writes to status, configuration or unmapped addresses change no flag.
- R6: If a set and a clear of the same flag arrive in the same cycle, the set wins. This can happen when both processors write in one cycle (dual-port use).
- R7: The configuration register reads NCH in bits 7:0 and 0 in all other bits. Command registers and unmapped addresses read 0. Status bits at or above NCH read 0.
- R8: irq_rx_pend[p] is the OR of the other processor's flags.
- R9: irq_tx_free[p] is 1 when any of p's own flags for implemented channels is 0.
- R10: Read data is combinational from the address and select in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Processor issuing the access (0 or 1) |
| bus_addr | input | 12 | Byte address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| peer_we | input | 1 | Write enable of a second command port, applied to processor !bus_sel's command register |
| peer_wdata | input | 32 | Command data for the second port |
| irq_rx_pend | output | 2 | Per-processor message-pending level |
| irq_tx_free | output | 2 | Per-processor channel-free level |

## Verification
If a flag is stored in the wrong bank or under the wrong channel, the error shows at the ports one cycle after the command. It appears on that processor's status read, on the partner's status window and on both interrupt levels. A clear that lands on the wrong side also shows in the next cycle: either the sender's flag stays high, or the receiver's own flag drops. The bench keeps its own model of both banks and compares every readable register after each random operation. A bad flag is therefore caught within one operation.

// File: rtl/mbx_flag_pkg.sv
package mbx_flag_pkg;
  parameter int unsigned NPROC      = 2;
  parameter int unsigned AW         = 12;
  parameter int unsigned DW         = 32;
  parameter int unsigned SET_SHIFT  = 16;
  parameter logic [AW-1:0] WIN_STRIDE = 12'h010;
  parameter logic [AW-1:0] CMD_OFS    = 12'h008;
  parameter logic [AW-1:0] STAT_OFS   = 12'h00C;
  parameter logic [AW-1:0] CFG_ADDR   = 12'h3F0;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_CMD  = 2'd1,
    REG_STAT = 2'd2,
    REG_CFG  = 2'd3
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e kind;
    logic      win;
  } reg_hit_t;

  function automatic reg_hit_t decode_addr(input logic [AW-1:0] a);
    reg_hit_t h;
    h.kind = REG_NONE;
    h.win  = 1'b0;
    if (a == CFG_ADDR) begin
      h.kind = REG_CFG;
    end else begin
      for (int p = 0; p < NPROC; p++) begin
        if (a == WIN_STRIDE * p[AW-1:0] + CMD_OFS) begin
          h.kind = REG_CMD;
          h.win  = p[0];
        end
        if (a == WIN_STRIDE * p[AW-1:0] + STAT_OFS) begin
          h.kind = REG_STAT;
          h.win  = p[0];
        end
      end
    end
    return h;
  endfunction
endpackage

// File: rtl/mbx_cmd_split.sv
module mbx_cmd_split
  import mbx_flag_pkg::*;
#(
  parameter int unsigned NCH = 16
) (
  input  logic           we,
  input  logic [DW-1:0]  wdata,
  output logic [NCH-1:0] set_mask,
  output logic [NCH-1:0] clr_mask
);
  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    if (we) begin
      set_mask = wdata[SET_SHIFT +: NCH];
      clr_mask = wdata[NCH-1:0];
    end
  end
endmodule

// File: rtl/mbx_flag_bank.sv
module mbx_flag_bank #(
  parameter int unsigned NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_mask,
  input  logic [NCH-1:0] clr_mask,
  output logic [NCH-1:0] flags
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flags[c] <= 1'b0;
      else if (set_mask[c]) flags[c] <= 1'b1;
      else if (clr_mask[c]) flags[c] <= 1'b0;
    end
  end
endmodule

// File: rtl/mbx_flag_ctrl.sv
module mbx_flag_ctrl
  import mbx_flag_pkg::*;
#(
  parameter int unsigned NCH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic [11:0]   bus_addr,
  input  logic          bus_we,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          peer_we,
  input  logic [31:0]   peer_wdata,
  output logic [1:0]    irq_rx_pend,
  output logic [1:0]    irq_tx_free
);
  reg_hit_t hit;
  logic [NPROC-1:0]          cmd_we;
  logic [NPROC-1:0][DW-1:0]  cmd_data;
  logic [NPROC-1:0][NCH-1:0] set_m, clr_m, flags;
  logic [NPROC-1:0][NCH-1:0] set_ev, clr_ev;

  assign hit = decode_addr(bus_addr);

  always_comb begin
    cmd_we   = '0;
    cmd_data = '0;
    if (bus_we && hit.kind == REG_CMD && hit.win == bus_sel) begin
      cmd_we[bus_sel]   = 1'b1;
      cmd_data[bus_sel] = bus_wdata;
    end
    if (peer_we) begin
      cmd_we[!bus_sel]   = 1'b1;
      cmd_data[!bus_sel] = peer_wdata;
    end
  end

  for (genvar p = 0; p < NPROC; p++) begin : g_proc
    mbx_cmd_split #(.NCH(NCH)) u_split (
      .we(cmd_we[p]), .wdata(cmd_data[p]),
      .set_mask(set_m[p]), .clr_mask(clr_m[p])
    );
    assign set_ev[p] = set_m[p];
    assign clr_ev[p] = clr_m[1-p];
    mbx_flag_bank #(.NCH(NCH)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .set_mask(set_ev[p]), .clr_mask(clr_ev[p]),
      .flags(flags[p])
    );
    assign irq_rx_pend[p] = |flags[1-p];
    assign irq_tx_free[p] = ~&flags[p];
  end

  always_comb begin
    bus_rdata = '0;
    case (hit.kind)
      REG_STAT: bus_rdata[NCH-1:0] = flags[hit.win];
      REG_CFG:  bus_rdata[7:0]     = 8'(NCH);
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mbx_flag_chk.sv
module mbx_flag_chk #(
  parameter int unsigned NCH = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0][NCH-1:0]  flags,
  input logic [1:0][NCH-1:0]  set_ev,
  input logic [1:0][NCH-1:0]  clr_ev,
  input logic [1:0]           irq_rx_pend,
  input logic [1:0]           irq_tx_free
);
  for (genvar p = 0; p < 2; p++) begin : g_p
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (set_ev[p] != '0) |=> ((flags[p] & $past(set_ev[p])) == $past(set_ev[p])));
    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_ev[p] & ~set_ev[p]) != '0 |=> ((flags[p] & $past(clr_ev[p] & ~set_ev[p])) == '0));
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (set_ev[p] == '0 && clr_ev[p] == '0) |=> $stable(flags[p]));
    assert_rx_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rx_pend[p] == (flags[1-p] != '0));
    assert_tx_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_tx_free[p] == (flags[p] != '1));
  end
endmodule

bind mbx_flag_ctrl mbx_flag_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .flags(flags), .set_ev(set_ev), .clr_ev(clr_ev),
  .irq_rx_pend(irq_rx_pend), .irq_tx_free(irq_tx_free)
);

// File: tb/mbx_flag_ctrl_tb.sv
module mbx_flag_ctrl_tb_top;
  localparam int NCH = 16;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0, peer_we = 0;
  logic [11:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, peer_wdata = 0, bus_rdata;
  logic [1:0] irq_rx_pend, irq_tx_free;
  int n_run = 0, n_fail = 0;
  logic [NCH-1:0] m0 = 0, m1 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_flag_ctrl #(.NCH(NCH)) dut_i (.*);

  initial begin
    #(CLK_PERIOD*150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual=hang expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  function automatic logic [11:0] stat_a(input int p); return 12'(p*16 + 12); endfunction
  function automatic logic [11:0] cmd_a(input int p);  return 12'(p*16 + 8);  endfunction

  function automatic logic [NCH-1:0] nxt(input logic [NCH-1:0] own,
      input logic [31:0] own_cmd, input logic own_v,
      input logic [31:0] oth_cmd, input logic oth_v);
    logic [NCH-1:0] s, c;
    s = own_v ? own_cmd[16 +: NCH] : '0;
    c = oth_v ? oth_cmd[NCH-1:0] : '0;
    return (own & ~c) | s;
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic rd(input int p, input logic [11:0] a, output logic [31:0] d);
    bus_sel = p[0]; bus_addr = a; bus_we = 0; peer_we = 0;
    #1; d = bus_rdata;
  endtask

  task automatic check_all(input string r);
    logic [31:0] d;
    rd(0, stat_a(0), d); chk({r, " stat0"}, d, 32'(m0));
    rd(1, stat_a(1), d); chk({r, " stat1"}, d, 32'(m1));
    chk({r, " R8 rx"}, 32'(irq_rx_pend), 32'({|m0, |m1}));
    chk({r, " R9 tx"}, 32'(irq_tx_free), 32'({~&m1, ~&m0}));
  endtask

  task automatic op(input int p, input logic [11:0] a, input logic we,
      input logic [31:0] wd, input logic pw, input logic [31:0] pd);
    logic v0, v1; logic [31:0] c0, c1;
    @(negedge clk);
    bus_sel = p[0]; bus_addr = a; bus_we = we; bus_wdata = wd;
    peer_we = pw; peer_wdata = pd;
    v0 = 0; v1 = 0; c0 = 0; c1 = 0;
    if (we && a == cmd_a(p)) begin
      if (p == 0) begin v0 = 1; c0 = wd; end else begin v1 = 1; c1 = wd; end
    end
    if (pw) begin
      if (p == 0) begin v1 = 1; c1 = pd; end else begin v0 = 1; c0 = pd; end
    end
    @(posedge clk);
    {m0, m1} = {nxt(m0, c0, v0, c1, v1), nxt(m1, c1, v1, c0, v0)};
    #1; bus_we = 0; peer_we = 0;
  endtask

  initial begin
    logic [31:0] d;
    process::self().srandom(32'd1234);
    #(CLK_PERIOD*2 + 2); rst_n = 1;
    check_all("R1 reset");
    rd(0, 12'h3F0, d); chk("R7 cfg p0", d, 32'(NCH));
    rd(1, 12'h3F0, d); chk("R2 cfg p1", d, 32'(NCH));
    rd(0, cmd_a(0), d); chk("R7 cmd reads 0", d, 0);
    // R3 set
    op(0, cmd_a(0), 1, 32'h0005_0000, 0, 0); check_all("R3 set");
    chk("R3 exact", 32'(m0), 32'h5);
    // R2 window of proc 0 readable by proc 1 select
    rd(1, stat_a(0), d); chk("R2 cross read", d, 32'h5);
    // R4 clear by receiver
    op(1, cmd_a(1), 1, 32'h0000_0001, 0, 0); check_all("R4 clear");
    chk("R4 exact", 32'(m0), 32'h4);
    // R5 zeros / wrong window / status writes
    op(1, cmd_a(1), 1, 32'h0, 0, 0); check_all("R5 zero");
    op(0, cmd_a(1), 1, 32'hFFFF_FFFF, 0, 0); check_all("R5 other window");
    op(0, stat_a(0), 1, 32'hFFFF_FFFF, 0, 0); check_all("R5 stat write");
    op(0, 12'h3F0, 1, 32'hFFFF_FFFF, 0, 0); check_all("R5 cfg write");
    chk("R5 exact", 32'(m0), 32'h4);
    // R6 set wins when both write
    op(0, cmd_a(0), 1, 32'h0004_0000, 1, 32'h0000_0004); check_all("R6 set wins");
    chk("R6 exact", 32'(m0), 32'h4);
    // R9 all full
    op(1, cmd_a(1), 1, 32'hFFFF_0000, 0, 0); check_all("R9 full");
    chk("R9 tx1", 32'(irq_tx_free[1]), 0);
    for (int i = 0; i < 400; i++) begin
      int p; logic [11:0] a; logic [31:0] w;
      p = $urandom_range(1);
      case ($urandom_range(3))
        0, 1: a = cmd_a(p);
        2: a = stat_a($urandom_range(1));
        default: a = 12'($urandom_range(1023));
      endcase
      w = $urandom();
      op(p, a, $urandom_range(1) == 1, w, $urandom_range(3) == 0, $urandom());
      check_all("R3 R4 R6 random");
      rd(p, a, d);
      if (a == 12'h3F0) chk("R10 cfg", d, 32'(NCH));
      else if (a == stat_a(0)) chk("R10 s0", d, 32'(m0));
      else if (a == stat_a(1)) chk("R10 s1", d, 32'(m1));
      else chk("R7 zero", d, 0);
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule